// File: doc/BRIEF.md
# Dynamic Trace Identification Unit

This unit sits beside the fetch stage of a processor core and names the dynamic instruction traces that the core runs. A trace is a chain of up to four basic blocks joined by control instructions. The unit only follows traces whose first address has been loaded into its small start table. Every other fetch passes by without any effect. The start table holds the frequently run entry points, so only a few traces are tracked.

Each fetch cycle gives the unit a program counter, a marker for the first instruction of a basic block, and flags for a conditional branch, an unconditional jump or a return, together with the resolved branch direction. A marked block start whose address matches a valid table entry opens a trace. The open trace then gathers one outcome bit for each conditional branch. It closes at a return or at the end of its fourth block, and the unit then pulses a done flag carrying the trace identifier: the start address, the outcome bits and the number of valid outcome bits. A later stage uses this identifier to look up a stored hash for the trace.

Top module: `trace_id_unit`

## Requirements
- R1: Reset leaves trace_done low and no trace open. A return fetched after reset, outside any monitored start, produces no done pulse.
- R2: A table write with tbl_wr_en high stores tbl_wr_addr and tbl_wr_valid into the entry at tbl_wr_idx. The new contents take effect for fetches in later cycles, not for a fetch in the same cycle. Writing valid 0 removes the address from monitoring.
- R3: A trace opens only when fetch_vld and fetch_bb_start are high and fetch_pc equals the address of a valid table entry. Fetches at any other address open nothing and cause no done pulse.
- R4: On done, trace_start_pc is the address of the trace's first block. trace_outcomes holds the branch outcomes (1 = taken, 0 = not taken), with the first outcome in bit 0 and the next ones in rising bit order. Unused bits are 0. trace_outcome_cnt is the number of valid outcome bits (0 to 4).
- R5: A jump ends a basic block and counts toward the length limit, but adds no outcome bit.
- R6: A return ends the open trace. trace_done is high for exactly the one cycle after the clock edge that takes in the closing fetch.
- R7: A trace closes on the control instruction that ends its fourth basic block. It never holds more than four blocks.
- R8: A monitored block start fetched while a trace is open closes the open trace with its current contents. The new trace is open from the next cycle, and the starting fetch's own control flags already apply to it.
- R9: If the fetch that starts a new trace over an open one is also a return, both traces close. The older trace's done comes first, and the new one-block trace's done follows in the next cycle.
- R10: When several control flags are set on one fetch, return wins over branch, and branch wins over jump.
- R11: Cycles with fetch_vld low are ignored: they neither open, extend nor close a trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Start table write strobe |
| tbl_wr_idx | input | 4 | Start table entry to write |
| tbl_wr_addr | input | 32 | Start address to store |
| tbl_wr_valid | input | 1 | Valid bit to store with the address |
| fetch_vld | input | 1 | Fetch slot holds an instruction |
| fetch_pc | input | 32 | Program counter of the fetched instruction |
| fetch_bb_start | input | 1 | Instruction is the first of a basic block |
| fetch_is_branch | input | 1 | Instruction is a conditional branch |
| fetch_is_jump | input | 1 | Instruction is an unconditional jump |
| fetch_is_ret | input | 1 | Instruction is a return |
| fetch_br_taken | input | 1 | Resolved direction of the branch, 1 = taken |
| trace_done | output | 1 | One-cycle pulse: a trace identifier is presented |
| trace_start_pc | output | 32 | Start address of the closed trace |
| trace_outcomes | output | 4 | Branch outcome bits, first outcome in bit 0 |
| trace_outcome_cnt | output | 3 | Number of valid outcome bits |

## Verification
Two events can meet in one cycle. One is closing an open trace because a new monitored start has arrived. The other is the new trace closing at once because that same starting fetch is a return. The bench provokes this by opening a trace, recording one taken branch, and then fetching a second monitored start flagged as a return. It expects two done pulses on consecutive cycles, older trace first, each with its own identifier, and then silence. A second collision case issues a table write and a fetch of the written address in the same cycle, and expects the fetch not to open a trace.

// File: rtl/trace_id_pkg.sv
package trace_id_pkg;

  typedef enum logic [1:0] {
    CTL_NONE   = 2'd0,
    CTL_JUMP   = 2'd1,
    CTL_BRANCH = 2'd2,
    CTL_RETURN = 2'd3
  } ctl_kind_e;

  // Priority: return over branch over jump.
  function automatic ctl_kind_e classify_ctl(input logic is_br, input logic is_jmp,
                                             input logic is_ret);
    ctl_kind_e k;
    if (is_ret)      k = CTL_RETURN;
    else if (is_br)  k = CTL_BRANCH;
    else if (is_jmp) k = CTL_JUMP;
    else             k = CTL_NONE;
    return k;
  endfunction

  function automatic logic ends_block(input ctl_kind_e k);
    return k != CTL_NONE;
  endfunction

endpackage

// File: rtl/start_table.sv
module start_table #(
  parameter int PC_W  = 32,
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_addr,
  input  logic             wr_valid,
  input  logic [PC_W-1:0]  look_pc,
  output logic             hit
);

  logic [DEPTH-1:0] match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [PC_W-1:0] addr_q;
    logic            vld_q;
    logic            sel;

    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)   vld_q <= 1'b0;
      else if (sel) vld_q <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (sel) addr_q <= wr_addr;
    end

    assign match[i] = vld_q && (addr_q == look_pc);
  end

  assign hit = |match;

endmodule

// File: rtl/trace_builder.sv
module trace_builder
  import trace_id_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int MAX_BLK = 4,
  parameter int CNT_W   = $clog2(MAX_BLK + 1),
  parameter int ID_W    = PC_W + MAX_BLK + CNT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_vld,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            fetch_bb_start,
  input  ctl_kind_e       ctl,
  input  logic            taken,
  input  logic            tbl_hit,
  output logic            trace_open,
  output logic            start_hit,
  output logic            evt_preempt,
  output logic            evt_close,
  output logic [ID_W-1:0] preempt_id,
  output logic [ID_W-1:0] close_id
);

  localparam logic [CNT_W-1:0] BLK_LIM = CNT_W'(MAX_BLK);

  logic               open_q;
  logic [PC_W-1:0]    start_q;
  logic [MAX_BLK-1:0] bits_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   blk_q;

  logic               proc_act;
  logic [PC_W-1:0]    base_start;
  logic [MAX_BLK-1:0] base_bits, p_bits;
  logic [CNT_W-1:0]   base_cnt, p_cnt;
  logic [CNT_W-1:0]   base_blk, p_blk;

  function automatic logic [MAX_BLK-1:0] put_outcome(input logic [MAX_BLK-1:0] bits,
                                                     input logic [CNT_W-1:0] pos,
                                                     input logic tk);
    logic [MAX_BLK-1:0] r;
    r = bits;
    for (int i = 0; i < MAX_BLK; i++) begin
      if (CNT_W'(i) == pos) r[i] = tk;
    end
    return r;
  endfunction

  always_comb begin
    start_hit   = fetch_vld && fetch_bb_start && tbl_hit;
    evt_preempt = open_q && start_hit;
    proc_act    = start_hit || (open_q && fetch_vld);

    if (start_hit) begin
      base_start = fetch_pc;
      base_bits  = '0;
      base_cnt   = '0;
      base_blk   = '0;
    end else begin
      base_start = start_q;
      base_bits  = bits_q;
      base_cnt   = cnt_q;
      base_blk   = blk_q;
    end

    p_bits = base_bits;
    p_cnt  = base_cnt;
    if (ctl == CTL_BRANCH) begin
      p_bits = put_outcome(base_bits, base_cnt, taken);
      p_cnt  = base_cnt + CNT_W'(1);
    end
    p_blk = ends_block(ctl) ? base_blk + CNT_W'(1) : base_blk;

    evt_close = proc_act &&
                ((ctl == CTL_RETURN) || (ends_block(ctl) && (p_blk == BLK_LIM)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (proc_act && evt_close)) begin
      open_q  <= 1'b0;
      start_q <= '0;
      bits_q  <= '0;
      cnt_q   <= '0;
      blk_q   <= '0;
    end else if (proc_act) begin
      open_q  <= 1'b1;
      start_q <= base_start;
      bits_q  <= p_bits;
      cnt_q   <= p_cnt;
      blk_q   <= p_blk;
    end
  end

  assign trace_open = open_q;
  assign preempt_id = {start_q, bits_q, cnt_q};
  assign close_id   = {base_start, p_bits, p_cnt};

endmodule

// File: rtl/done_queue.sv
module done_queue #(
  parameter int ID_W = 39
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_vld,
  input  logic [ID_W-1:0] a_id,
  input  logic            b_vld,
  input  logic [ID_W-1:0] b_id,
  output logic            done,
  output logic [ID_W-1:0] id,
  output logic            hold_vld
);

  logic            done_q, hold_q;
  logic [ID_W-1:0] id_q, hold_id_q;
  logic            first_vld, second_vld;
  logic [ID_W-1:0] first_id, second_id;

  // Order of service: held entry, then older-trace close, then new close.
  always_comb begin
    if (hold_q) begin
      first_vld  = 1'b1;
      first_id   = hold_id_q;
      second_vld = a_vld || b_vld;
      second_id  = a_vld ? a_id : b_id;
    end else begin
      first_vld  = a_vld || b_vld;
      first_id   = a_vld ? a_id : b_id;
      second_vld = a_vld && b_vld;
      second_id  = b_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      id_q      <= '0;
      hold_q    <= 1'b0;
      hold_id_q <= '0;
    end else begin
      done_q <= first_vld;
      if (first_vld) id_q <= first_id;
      hold_q <= second_vld;
      if (second_vld) hold_id_q <= second_id;
    end
  end

  assign done     = done_q;
  assign id       = id_q;
  assign hold_vld = hold_q;

endmodule

// File: rtl/trace_id_unit.sv
module trace_id_unit
  import trace_id_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DEPTH   = 16,
  parameter int MAX_BLK = 4,
  parameter int IDX_W   = $clog2(DEPTH),
  parameter int CNT_W   = $clog2(MAX_BLK + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_wr_en,
  input  logic [IDX_W-1:0]   tbl_wr_idx,
  input  logic [PC_W-1:0]    tbl_wr_addr,
  input  logic               tbl_wr_valid,
  input  logic               fetch_vld,
  input  logic [PC_W-1:0]    fetch_pc,
  input  logic               fetch_bb_start,
  input  logic               fetch_is_branch,
  input  logic               fetch_is_jump,
  input  logic               fetch_is_ret,
  input  logic               fetch_br_taken,
  output logic               trace_done,
  output logic [PC_W-1:0]    trace_start_pc,
  output logic [MAX_BLK-1:0] trace_outcomes,
  output logic [CNT_W-1:0]   trace_outcome_cnt
);

  localparam int ID_W = PC_W + MAX_BLK + CNT_W;

  ctl_kind_e       ctl_kind;
  logic            tbl_hit;
  logic            bld_open, bld_start_hit, bld_preempt, bld_close;
  logic [ID_W-1:0] preempt_id, close_id, out_id;
  logic            q_hold_vld;

  assign ctl_kind = classify_ctl(fetch_is_branch, fetch_is_jump, fetch_is_ret);

  start_table #(.PC_W(PC_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_addr(tbl_wr_addr),
    .wr_valid(tbl_wr_valid), .look_pc(fetch_pc), .hit(tbl_hit)
  );

  trace_builder #(.PC_W(PC_W), .MAX_BLK(MAX_BLK), .CNT_W(CNT_W), .ID_W(ID_W)) u_build (
    .clk(clk), .rst_n(rst_n),
    .fetch_vld(fetch_vld), .fetch_pc(fetch_pc), .fetch_bb_start(fetch_bb_start),
    .ctl(ctl_kind), .taken(fetch_br_taken), .tbl_hit(tbl_hit),
    .trace_open(bld_open), .start_hit(bld_start_hit),
    .evt_preempt(bld_preempt), .evt_close(bld_close),
    .preempt_id(preempt_id), .close_id(close_id)
  );

  done_queue #(.ID_W(ID_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .a_vld(bld_preempt), .a_id(preempt_id),
    .b_vld(bld_close), .b_id(close_id),
    .done(trace_done), .id(out_id), .hold_vld(q_hold_vld)
  );

  assign trace_start_pc    = out_id[ID_W-1 -: PC_W];
  assign trace_outcomes    = out_id[CNT_W +: MAX_BLK];
  assign trace_outcome_cnt = out_id[CNT_W-1:0];

endmodule

// File: rtl/trace_id_unit_chk.sv
module trace_id_unit_chk #(
  parameter int MAX_BLK = 4,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trace_done,
  input logic [MAX_BLK-1:0] trace_outcomes,
  input logic [CNT_W-1:0]   trace_outcome_cnt,
  input logic               trace_open,
  input logic               start_hit,
  input logic               evt_preempt,
  input logic               evt_close,
  input logic               hold_vld
);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_vld && evt_preempt && evt_close));

  // R6
  done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_done |-> $past(evt_close || evt_preempt || hold_vld));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_done |-> (trace_outcome_cnt <= CNT_W'(MAX_BLK)));

  // R4
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_done |-> ((trace_outcomes >> trace_outcome_cnt) == '0));

  // R3
  open_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trace_open) |-> $past(start_hit));

  // R8
  preempt_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_preempt && !evt_close) |=> trace_open);

endmodule

bind trace_id_unit trace_id_unit_chk #(.MAX_BLK(MAX_BLK), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .trace_done(trace_done), .trace_outcomes(trace_outcomes),
  .trace_outcome_cnt(trace_outcome_cnt),
  .trace_open(bld_open), .start_hit(bld_start_hit),
  .evt_preempt(bld_preempt), .evt_close(bld_close), .hold_vld(q_hold_vld)
);

// File: tb/trace_id_unit_test.sv
`timescale 1ns/1ps
module trace_id_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_wr_en, tbl_wr_valid;
  logic [3:0]  tbl_wr_idx;
  logic [31:0] tbl_wr_addr;
  logic        fetch_vld, fetch_bb_start, fetch_is_branch, fetch_is_jump, fetch_is_ret;
  logic        fetch_br_taken;
  logic [31:0] fetch_pc;
  logic        trace_done;
  logic [31:0] trace_start_pc;
  logic [3:0]  trace_outcomes;
  logic [2:0]  trace_outcome_cnt;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  trace_id_unit uut (
    .clk(clk), .rst_n(rst_n),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_addr(tbl_wr_addr),
    .tbl_wr_valid(tbl_wr_valid),
    .fetch_vld(fetch_vld), .fetch_pc(fetch_pc), .fetch_bb_start(fetch_bb_start),
    .fetch_is_branch(fetch_is_branch), .fetch_is_jump(fetch_is_jump),
    .fetch_is_ret(fetch_is_ret), .fetch_br_taken(fetch_br_taken),
    .trace_done(trace_done), .trace_start_pc(trace_start_pc),
    .trace_outcomes(trace_outcomes), .trace_outcome_cnt(trace_outcome_cnt)
  );

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  // Outputs are sampled at a falling edge, after the rising edge that took the fetch.
  task automatic expect_none(input string req);
    checks++;
    if (trace_done !== 1'b0) begin
      errors++;
      $display("FAIL %s: trace_done=%b expected 0", req, trace_done);
    end
  endtask

  task automatic expect_id(input string req, input logic [31:0] pc,
                           input logic [3:0] bits, input logic [2:0] cnt);
    checks++;
    if (trace_done !== 1'b1 || trace_start_pc !== pc ||
        trace_outcomes !== bits || trace_outcome_cnt !== cnt) begin
      errors++;
      $display("FAIL %s: done=%b pc=%h bits=%b cnt=%0d expected done=1 pc=%h bits=%b cnt=%0d",
               req, trace_done, trace_start_pc, trace_outcomes, trace_outcome_cnt,
               pc, bits, cnt);
    end
  endtask

  task automatic fetch(input logic [31:0] pc, input logic bb, input logic br,
                       input logic jmp, input logic ret, input logic tk);
    fetch_vld = 1'b1; fetch_pc = pc; fetch_bb_start = bb;
    fetch_is_branch = br; fetch_is_jump = jmp; fetch_is_ret = ret; fetch_br_taken = tk;
    @(negedge clk);
  endtask

  task automatic idle();
    fetch_vld = 1'b0; fetch_bb_start = 1'b0; fetch_is_branch = 1'b0;
    fetch_is_jump = 1'b0; fetch_is_ret = 1'b0; fetch_br_taken = 1'b0;
    @(negedge clk);
  endtask

  task automatic tbl_write(input logic [3:0] idx, input logic [31:0] addr, input logic v);
    fetch_vld = 1'b0;
    tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_addr = addr; tbl_wr_valid = v;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic t_reset();
    expect_none("R1 reset state");
    fetch(32'h0000_1000, 1, 0, 0, 1, 0);
    expect_none("R1 return with nothing open");
  endtask

  task automatic t_table_write();
    // Write and fetch the written address in the same cycle: no trace opens.
    tbl_wr_en = 1'b1; tbl_wr_idx = 4'd2; tbl_wr_addr = 32'h0000_1000; tbl_wr_valid = 1'b1;
    fetch(32'h0000_1000, 1, 0, 0, 1, 0);
    tbl_wr_en = 1'b0;
    expect_none("R2 same-cycle write not visible");
    fetch(32'h0000_1000, 1, 0, 0, 1, 0);
    expect_id("R2 R6 written entry opens and return closes", 32'h0000_1000, 4'b0000, 3'd0);
    idle();
    expect_none("R6 done lasts one cycle");
    tbl_write(4'd5, 32'h0000_2000, 1'b1);
  endtask

  task automatic t_pass_through();
    fetch(32'h0000_1004, 1, 1, 0, 0, 1);
    expect_none("R3 unmonitored block start");
    fetch(32'h0000_1008, 0, 0, 0, 1, 0);
    expect_none("R3 unmonitored return");
  endtask

  task automatic t_length_limit();
    fetch(32'h0000_1000, 1, 1, 0, 0, 1);
    expect_none("R7 block 1");
    fetch(32'h0000_1008, 0, 0, 0, 0, 0);
    fetch(32'h0000_1010, 1, 1, 0, 0, 0);
    expect_none("R7 block 2");
    fetch(32'h0000_1020, 1, 0, 1, 0, 0);
    expect_none("R5 R7 block 3 ends in jump");
    fetch(32'h0000_1030, 1, 1, 0, 0, 1);
    expect_id("R4 R5 R7 four blocks close", 32'h0000_1000, 4'b0101, 3'd3);
    fetch(32'h0000_1040, 1, 1, 0, 0, 1);
    expect_none("R7 trace stays closed");
    fetch(32'h0000_1000, 1, 1, 0, 0, 1);
    fetch(32'h0000_1010, 1, 1, 0, 0, 1);
    fetch(32'h0000_1020, 1, 1, 0, 0, 0);
    fetch(32'h0000_1030, 1, 1, 0, 0, 1);
    expect_id("R4 R7 four branches", 32'h0000_1000, 4'b1011, 3'd4);
  endtask

  task automatic t_early_return();
    fetch(32'h0000_1000, 1, 1, 0, 0, 1);
    fetch(32'h0000_1040, 1, 0, 0, 1, 0);
    expect_id("R4 R6 early return", 32'h0000_1000, 4'b0001, 3'd1);
  endtask

  task automatic t_priority();
    fetch(32'h0000_1000, 1, 0, 1, 0, 0);
    fetch(32'h0000_1010, 1, 1, 0, 1, 1);
    expect_id("R10 return beats branch", 32'h0000_1000, 4'b0000, 3'd0);
    fetch(32'h0000_1000, 1, 1, 1, 0, 1);
    fetch(32'h0000_1010, 1, 0, 0, 1, 0);
    expect_id("R10 branch beats jump", 32'h0000_1000, 4'b0001, 3'd1);
  endtask

  task automatic t_invalid_slots();
    fetch(32'h0000_1000, 1, 1, 0, 0, 1);
    fetch_vld = 1'b0; fetch_pc = 32'h0000_2000; fetch_bb_start = 1'b1;
    fetch_is_ret = 1'b1; fetch_is_branch = 1'b0;
    @(negedge clk);
    expect_none("R11 idle slot with return ignored");
    @(negedge clk);
    expect_none("R11 idle slot at monitored start ignored");
    fetch(32'h0000_1050, 1, 0, 0, 1, 0);
    expect_id("R11 trace intact after idle slots", 32'h0000_1000, 4'b0001, 3'd1);
  endtask

  task automatic t_preempt();
    fetch(32'h0000_1000, 1, 1, 0, 0, 1);
    fetch(32'h0000_2000, 1, 1, 0, 0, 0);
    expect_id("R8 open trace closed by new start", 32'h0000_1000, 4'b0001, 3'd1);
    fetch(32'h0000_2010, 1, 0, 0, 1, 0);
    expect_id("R8 new trace kept its first branch", 32'h0000_2000, 4'b0000, 3'd1);
  endtask

  task automatic t_preempt_return();
    fetch(32'h0000_1000, 1, 1, 0, 0, 1);
    fetch(32'h0000_2000, 1, 0, 0, 1, 0);
    expect_id("R9 older trace first", 32'h0000_1000, 4'b0001, 3'd1);
    idle();
    expect_id("R9 new one-block trace next", 32'h0000_2000, 4'b0000, 3'd0);
    idle();
    expect_none("R9 nothing after both");
  endtask

  task automatic t_clear_entry();
    tbl_write(4'd2, 32'h0000_1000, 1'b0);
    fetch(32'h0000_1000, 1, 0, 0, 1, 0);
    expect_none("R2 cleared entry no longer monitored");
  endtask

  task automatic t_reset_mid_trace();
    fetch(32'h0000_2000, 1, 1, 0, 0, 1);
    fetch_vld = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    expect_none("R1 done low after reset");
    fetch(32'h0000_2040, 1, 0, 0, 1, 0);
    expect_none("R1 reset dropped open trace");
  endtask

  initial begin
    rst_n = 1'b0;
    tbl_wr_en = 1'b0; tbl_wr_idx = '0; tbl_wr_addr = '0; tbl_wr_valid = 1'b0;
    fetch_vld = 1'b0; fetch_pc = '0; fetch_bb_start = 1'b0; fetch_is_branch = 1'b0;
    fetch_is_jump = 1'b0; fetch_is_ret = 1'b0; fetch_br_taken = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_table_write();
    t_pass_through();
    t_length_limit();
    t_early_return();
    t_priority();
    t_invalid_slots();
    t_preempt();
    t_preempt_return();
    t_clear_entry();
    t_reset_mid_trace();
    summary();
    $finish;
  end

endmodule